// File: doc/BRIEF.md
# Buck Light-Load Mode Controller

This block decides, once per switching period, whether a synchronous buck converter runs in fixed-frequency PWM operation or in light-load hysteretic operation. In hysteretic operation the low-side switch behaves like a diode. A strobe marks the end of each low-side conduction interval. On that strobe the block reads a one-bit phase-node polarity comparator. A positive phase node at that moment means the inductor current has reversed, so the load is light. A negative phase node means the current is still flowing forward.

A change of mode in either direction needs a run of consecutive same-polarity samples, so the block does not chatter when the load sits near the boundary. In hysteretic mode a load step can pull the output down to the lower hysteretic limit. When that happens the block returns to PWM at once and skips the count. A forced-continuous input keeps the converter in PWM. The enable input and the reset both return the block to PWM with its history cleared. The analog comparators, the modulator and the gate drivers are outside this block; every comparator result arrives as a synchronous single bit.

Top module: `buck_ll_mode_ctrl`

## Requirements
- R1: After reset, and at the clock edge after `en_i` is seen low, the mode is PWM (`mode_hyst_o`=0), `diode_emu_o` is 0 and the consecutive-sample count is zero. After `en_i` returns high, a fresh run of STREAK_LEN samples is needed before any mode change.
- R2: In PWM, the STREAK_LEN-th consecutive strobed sample with `phase_pos_i`=1 (1 = positive phase node) sets `mode_hyst_o`=1 at that clock edge. STREAK_LEN-1 such samples leave the mode at PWM.
- R3: In hysteretic mode, the STREAK_LEN-th consecutive strobed sample with `phase_pos_i`=0 returns the mode to PWM at that edge. STREAK_LEN-1 such samples leave the mode unchanged.
- R4: A strobed sample of the polarity opposite to the one that leads out of the current mode clears the count to zero.
- R5: In hysteretic mode, `hyst_low_i`=1 returns the mode to PWM at the next clock edge with the count cleared, whatever the polarity count is.
- R6: While `force_ccm_i`=1 the mode is PWM from the next edge on and the count is held at zero. This holds even when the assertion falls on the cycle of a sample that would complete a run.
- R7: `diode_emu_o` is 1 exactly when the block is enabled and in hysteretic mode, so both switches stay off between current pulses.
- R8: `phase_pos_i` has no effect in cycles without `sample_i`.
- R9: In PWM, `hyst_low_i` has no effect on the mode or on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| sample_i | input | 1 | Strobe at the end of low-side conduction, one per switching period |
| phase_pos_i | input | 1 | Phase comparator: 1 = phase node positive |
| hyst_low_i | input | 1 | Output at or below the lower hysteretic limit |
| force_ccm_i | input | 1 | Force continuous PWM operation |
| mode_hyst_o | output | 1 | 1 = hysteretic mode, 0 = PWM |
| diode_emu_o | output | 1 | Diode emulation enable for the low-side switch |

## Verification
Two events can land in one cycle. In the first, forced-continuous is asserted in the same cycle as the sample that would complete a run into hysteretic mode. In the second, the lower-limit flag arrives in PWM partway through a positive run. The bench provokes both with directed sequences of seven samples, followed by the colliding cycle and one further sample. It then judges whether the mode changed, and whether the count was cleared or kept. Clearing is judged by how many later samples it takes to flip the mode: a missed clear flips the mode too early, and a wrong clear flips it too late.

// File: rtl/llm_pkg.sv
package llm_pkg;
  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } op_mode_e;
endpackage

// File: rtl/llm_streak_cnt.sv
module llm_streak_cnt #(
  parameter int unsigned LEN   = 8,
  parameter int unsigned CNT_W = $clog2(LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic             match_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign hit_o = sample_i & match_i & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)              cnt_d = '0;
    else if (sample_i) begin
      if (!match_i || hit_o) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/llm_mode_fsm.sv
module llm_mode_fsm
  import llm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     force_ccm_i,
  input  logic     hyst_low_i,
  input  logic     hit_i,
  output op_mode_e mode_o,
  output logic     clr_o
);
  op_mode_e mode_q, mode_d;
  logic     escape;

  // load-step escape only meaningful while hysteretic
  assign escape = (mode_q == MODE_HYST) & hyst_low_i;
  assign clr_o  = ~en_i | force_ccm_i | escape;

  always_comb begin
    mode_d = mode_q;
    if (clr_o)      mode_d = MODE_PWM;
    else if (hit_i) mode_d = (mode_q == MODE_PWM) ? MODE_HYST : MODE_PWM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PWM;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/buck_ll_mode_ctrl.sv
module buck_ll_mode_ctrl
  import llm_pkg::*;
#(
  parameter int unsigned STREAK_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sample_i,
  input  logic phase_pos_i,
  input  logic hyst_low_i,
  input  logic force_ccm_i,
  output logic mode_hyst_o,
  output logic diode_emu_o
);
  localparam int unsigned CNT_W = $clog2(STREAK_LEN + 1);

  op_mode_e         mode;
  logic             clr, hit, match;
  logic [CNT_W-1:0] streak_cnt;

  // polarity that argues for leaving the current mode
  assign match = (mode == MODE_PWM) ? phase_pos_i : ~phase_pos_i;

  llm_streak_cnt #(.LEN(STREAK_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .sample_i (sample_i),
    .match_i  (match),
    .hit_o    (hit),
    .cnt_o    (streak_cnt)
  );

  llm_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .force_ccm_i (force_ccm_i),
    .hyst_low_i  (hyst_low_i),
    .hit_i       (hit),
    .mode_o      (mode),
    .clr_o       (clr)
  );

  assign mode_hyst_o = (mode == MODE_HYST);
  assign diode_emu_o = en_i & (mode == MODE_HYST);
endmodule

// File: rtl/llm_mode_chk.sv
module llm_mode_chk #(
  parameter int unsigned LEN   = 8,
  parameter int unsigned CNT_W = $clog2(LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             sample_i,
  input logic             phase_pos_i,
  input logic             hyst_low_i,
  input logic             force_ccm_i,
  input logic             mode_hyst_o,
  input logic             diode_emu_o,
  input logic [CNT_W-1:0] cnt_i
);
  a_r1_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!mode_hyst_o && cnt_i == '0));

  a_r2_entry_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_hyst_o) |-> $past(sample_i && phase_pos_i && en_i && !force_ccm_i));

  a_r3_exit_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_hyst_o) |-> $past(!en_i || force_ccm_i || hyst_low_i || (sample_i && !phase_pos_i)));

  a_r4_opposite_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && (phase_pos_i == mode_hyst_o)) |=> cnt_i == '0);

  a_r5_escape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_hyst_o && hyst_low_i) |=> (!mode_hyst_o && cnt_i == '0));

  a_r6_force_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ccm_i |=> (!mode_hyst_o && cnt_i == '0));

  a_r7_diode_in_hyst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diode_emu_o |-> (mode_hyst_o && en_i));

  a_r8_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && en_i && !force_ccm_i && !(mode_hyst_o && hyst_low_i)) |=> ($stable(cnt_i) && $stable(mode_hyst_o)));

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CNT_W'(LEN));
endmodule

bind buck_ll_mode_ctrl llm_mode_chk #(.LEN(STREAK_LEN), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .sample_i    (sample_i),
  .phase_pos_i (phase_pos_i),
  .hyst_low_i  (hyst_low_i),
  .force_ccm_i (force_ccm_i),
  .mode_hyst_o (mode_hyst_o),
  .diode_emu_o (diode_emu_o),
  .cnt_i       (streak_cnt)
);

// File: tb/buck_ll_mode_ctrl_bench.sv
module buck_ll_mode_ctrl_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic sample_i = 1'b0, phase_pos_i = 1'b0, hyst_low_i = 1'b0, force_ccm_i = 1'b0;
  logic mode_hyst_o, diode_emu_o;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  buck_ll_mode_ctrl #(.STREAK_LEN(N)) u_buck_ll_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .sample_i(sample_i),
    .phase_pos_i(phase_pos_i), .hyst_low_i(hyst_low_i), .force_ccm_i(force_ccm_i),
    .mode_hyst_o(mode_hyst_o), .diode_emu_o(diode_emu_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one clock: inputs applied at a falling edge, result read at the next
  task automatic tick(input logic s, input logic p, input logic l, input logic f);
    sample_i = s; phase_pos_i = p; hyst_low_i = l; force_ccm_i = f;
    @(negedge clk);
    sample_i = 1'b0; hyst_low_i = 1'b0; force_ccm_i = 1'b0;
  endtask

  task automatic burst(input int n, input logic p);
    for (int i = 0; i < n; i++) tick(1'b1, p, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 reset mode", mode_hyst_o, 1'b0);
    chk("R1 reset diode", diode_emu_o, 1'b0);
  endtask

  task automatic t_entry();
    burst(N - 1, 1'b1);
    chk("R2 seven positive stay pwm", mode_hyst_o, 1'b0);
    burst(1, 1'b1);
    chk("R2 eighth positive enters hyst", mode_hyst_o, 1'b1);
    chk("R7 diode on in hyst", diode_emu_o, 1'b1);
  endtask

  task automatic t_exit();
    burst(N - 1, 1'b0);
    chk("R3 seven negative stay hyst", mode_hyst_o, 1'b1);
    burst(1, 1'b0);
    chk("R3 eighth negative returns pwm", mode_hyst_o, 1'b0);
    chk("R7 diode off in pwm", diode_emu_o, 1'b0);
  endtask

  task automatic t_break();
    burst(N - 1, 1'b1);
    burst(1, 1'b0);
    burst(N - 1, 1'b1);
    chk("R4 broken run no entry", mode_hyst_o, 1'b0);
    burst(1, 1'b1);
    chk("R4 full run after clear enters", mode_hyst_o, 1'b1);
    burst(N - 1, 1'b0);
    burst(1, 1'b1);
    burst(N - 1, 1'b0);
    chk("R4 broken negative run stays hyst", mode_hyst_o, 1'b1);
    burst(1, 1'b0);
    chk("R4 full negative run exits", mode_hyst_o, 1'b0);
  endtask

  task automatic t_no_strobe();
    burst(N - 1, 1'b1);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 unstrobed polarity ignored", mode_hyst_o, 1'b0);
    burst(1, 1'b1);
    chk("R8 count kept across idle", mode_hyst_o, 1'b1);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 unstrobed negative ignored", mode_hyst_o, 1'b1);
  endtask

  task automatic t_escape();
    burst(N - 1, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 load step returns pwm", mode_hyst_o, 1'b0);
    burst(1, 1'b1);
    chk("R5 count cleared by escape", mode_hyst_o, 1'b0);
    burst(N - 2, 1'b1);
    chk("R5 still pwm before full run", mode_hyst_o, 1'b0);
    burst(1, 1'b1);
    chk("R5 run after escape enters", mode_hyst_o, 1'b1);
  endtask

  task automatic t_pwm_low();
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 escape from hyst", mode_hyst_o, 1'b0);
    burst(N - 1, 1'b1);
    tick(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 low flag ignored in pwm", mode_hyst_o, 1'b0);
    burst(1, 1'b1);
    chk("R9 count kept through low flag", mode_hyst_o, 1'b1);
    tick(1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_force();
    for (int i = 0; i < N + 2; i++) tick(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R6 forced stays pwm", mode_hyst_o, 1'b0);
    burst(N - 1, 1'b1);
    tick(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R6 force beats completing sample", mode_hyst_o, 1'b0);
    burst(1, 1'b1);
    chk("R6 count cleared by force", mode_hyst_o, 1'b0);
    burst(N - 1, 1'b1);
    chk("R6 full run after force enters", mode_hyst_o, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 force exits hyst", mode_hyst_o, 1'b0);
  endtask

  task automatic t_disable();
    burst(N, 1'b1);
    chk("R1 in hyst before disable", mode_hyst_o, 1'b1);
    en_i = 1'b0;
    #1;
    chk("R7 diode off when disabled", diode_emu_o, 1'b0);
    @(negedge clk);
    chk("R1 disable returns pwm", mode_hyst_o, 1'b0);
    burst(N - 1, 1'b1);
    chk("R1 disabled ignores samples", mode_hyst_o, 1'b0);
    en_i = 1'b1;
    burst(1, 1'b1);
    chk("R1 count cleared while disabled", mode_hyst_o, 1'b0);
    burst(N - 1, 1'b1);
    chk("R1 full run after enable", mode_hyst_o, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry();
    t_exit();
    t_break();
    t_no_strobe();
    t_escape();
    t_pwm_low();
    t_force();
    t_disable();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule